// File: doc/BRIEF.md
# Multi-Line Write-Combining Buffer

This block gathers write-combining stores into a small pool of line buffers, each covering one aligned 64-byte line. A store whose line matches no open buffer claims a free buffer. A store to a line that is already open merges its enabled bytes into that buffer. Every buffer keeps a per-byte valid mask.

When a flush event arrives, the block drains every open buffer as one line transaction on a ready/valid output. It sends them strictly in the order the buffers were opened, not in address order. Three things start a flush: an uncached access, an explicit flush request, or a store to a new line while every buffer is occupied.

While a drain is in progress the store port is stalled. A buffer returns to the free pool only once its transaction has been accepted downstream.

Top module: `wc_line_combiner`

## Requirements
- R1: After reset no buffer is open, `out_valid` is 0 and `st_ready` is 1.
- R2: A store to a line that no buffer holds opens a buffer. That buffer's transaction carries the line address, which is `st_addr` with its low 6 bits cleared.
- R3: Within a line, the 8-byte word selected by `st_addr[5:3]` receives the enabled bytes: byte lane b of `st_data` (bits 8b+7:8b, enabled by `st_be[b]`) lands in line byte 8*word+b. `out_mask` bit k is 1 exactly when line byte k was written since the buffer opened. Bytes that were never written read as 0. A later store overwrites only its own enabled bytes.
- R4: A store that hits an open line merges into it and does not change that buffer's place in the drain order.
- R5: A one-cycle pulse on `flush_req` emits every open buffer, oldest-opened first, whatever their addresses.
- R6: A one-cycle pulse on `uc_req` flushes exactly as `flush_req` does.
- R7: A store to a new line while all buffers are open is held off (`st_ready` 0). All open buffers drain in open order. The store is then accepted into a fresh buffer.
- R8: While transactions are draining, `st_ready` is 0 and no store is taken.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_addr`, `out_data` and `out_mask` hold their values. A buffer is freed only on acceptance.
- R10: A flush event with no buffer open produces no transaction and leaves `st_ready` at 1.
- R11: No two buffers ever hold the same line: repeated stores to one line yield a single transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Store byte address (8-byte aligned) |
| st_data | input | 64 | Store data, byte lane b in bits 8b+7:8b |
| st_be | input | 8 | Per-lane byte enables |
| flush_req | input | 1 | Explicit flush request |
| uc_req | input | 1 | Uncached access seen, forces a flush |
| out_valid | output | 1 | Line transaction present |
| out_ready | input | 1 | Downstream accepts the transaction |
| out_addr | output | ADDR_W | Line address, low 6 bits zero |
| out_data | output | 512 | Line data, byte k in bits 8k+7:8k |
| out_mask | output | 64 | Byte valid mask, bit k for line byte k |

## Verification
The bench builds the block with its defaults: four buffers, 32-bit addresses and 8-byte store words. With only four buffers, a fifth distinct line reaches the all-occupied case after a few stores. That makes the stalled store, the forced drain and the re-acceptance directly observable. The lines are opened in a scrambled address order, and the output order is checked against that open order, so an address-sorted drain would be caught. Backpressure is held for several cycles to check that the payload stays stable and that the buffers stay held until each transaction is accepted.

// File: rtl/wcb_pkg.sv
// Shared constants and helpers for the write-combining buffer.
// Assumes lines are a whole number of store words.
package wcb_pkg;
    parameter int LINE_BYTES_DEF = 64;
    parameter int WORD_BYTES_DEF = 8;
    parameter int NUM_BUF_DEF    = 4;
endpackage

// File: rtl/wcb_order_fifo.sv
// Records buffer indices in the order their lines were opened.
// Assumes DEPTH equals the number of buffers, so a push never meets a full
// queue unless a pop happens in the same cycle.
module wcb_order_fifo #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [IDX_W-1:0]           push_idx,
    input  logic                       pop,
    output logic [IDX_W-1:0]           head_idx,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0] slots [DEPTH];
    logic [IDX_W-1:0] wr_ptr;
    logic [IDX_W-1:0] rd_ptr;

    // advance a pointer around a queue of any depth
    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // write side, read side and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_idx;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_idx = slots[rd_ptr];

    // R7
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == CNT_W'(DEPTH)) |-> pop);
    // R9
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/wcb_free_pick.sv
// Picks the lowest-numbered idle buffer.
// Assumes NUM_BUF >= 2 so that an index has at least one bit.
module wcb_free_pick #(
    parameter int NUM_BUF = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_BUF-1:0] busy,
    output logic [IDX_W-1:0]   free_idx,
    output logic               any_free
);
    // scan from the top so the lowest idle index wins
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wcb_line_slot.sv
// One line buffer: line tag, line data and per-byte valid mask.
// Assumes alloc and merge never rise together, and that release_i only
// comes while the buffer is busy.
module wcb_line_slot #(
    parameter int TAG_W      = 26,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BYTES = 8,
    parameter int WIDX_W     = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc,
    input  logic                      merge,
    input  logic                      release_i,
    input  logic [TAG_W-1:0]          tag_in,
    input  logic [WIDX_W-1:0]         word_sel,
    input  logic [WORD_BYTES*8-1:0]   wdata,
    input  logic [WORD_BYTES-1:0]     wbe,
    output logic                      busy,
    output logic                      hit,
    output logic [TAG_W-1:0]          tag,
    output logic [LINE_BYTES*8-1:0]   data,
    output logic [LINE_BYTES-1:0]     mask
);
    // an open buffer matches a store to the same line
    assign hit = busy && (tag == tag_in);

    // open, fill, merge and release the buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            tag  <= '0;
            data <= '0;
            mask <= '0;
        end else begin
            if (release_i) busy <= 1'b0;
            if (alloc) begin
                busy <= 1'b1;
                tag  <= tag_in;
            end
            if (alloc || merge) begin
                for (int b = 0; b < LINE_BYTES; b++) begin
                    if ((b / WORD_BYTES) == int'(word_sel) && wbe[b % WORD_BYTES]) begin
                        data[b*8 +: 8] <= wdata[(b % WORD_BYTES)*8 +: 8];
                        mask[b]        <= 1'b1;
                    end else if (alloc) begin
                        data[b*8 +: 8] <= 8'h00;
                        mask[b]        <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wc_line_combiner.sv
// Write-combining buffer with several line buffers that drain in open order.
// Stores merge into open lines. A flush request, an uncached access or a
// miss with no idle buffer drains every open buffer, oldest first.
// Assumes st_addr is word aligned and NUM_BUF >= 2.
module wc_line_combiner
    import wcb_pkg::*;
#(
    parameter int NUM_BUF    = NUM_BUF_DEF,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = LINE_BYTES_DEF,
    parameter int WORD_BYTES = WORD_BYTES_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [WORD_BYTES*8-1:0] st_data,
    input  logic [WORD_BYTES-1:0]   st_be,
    input  logic                    flush_req,
    input  logic                    uc_req,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [ADDR_W-1:0]       out_addr,
    output logic [LINE_BYTES*8-1:0] out_data,
    output logic [LINE_BYTES-1:0]   out_mask
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WOFF_W = $clog2(WORD_BYTES);
    localparam int WIDX_W = OFF_W - WOFF_W;
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int IDX_W  = $clog2(NUM_BUF);
    localparam int CNT_W  = $clog2(NUM_BUF + 1);

    logic [NUM_BUF-1:0]    slot_busy, hit_vec, alloc_vec, merge_vec, rel_vec;
    logic [TAG_W-1:0]      slot_tag  [NUM_BUF];
    logic [LINE_BYTES*8-1:0] slot_data [NUM_BUF];
    logic [LINE_BYTES-1:0] slot_mask [NUM_BUF];

    logic [TAG_W-1:0]  st_tag;
    logic [WIDX_W-1:0] st_word;
    logic [IDX_W-1:0]  free_idx, head_idx;
    logic [CNT_W-1:0]  open_cnt;
    logic any_free, hit_any, flush_trig, accept, pop, start_drain, draining;

    assign st_tag  = st_addr[ADDR_W-1:OFF_W];
    assign st_word = st_addr[OFF_W-1:WOFF_W];
    assign hit_any = |hit_vec;
    assign flush_trig = flush_req || uc_req;

    // take a store only when no drain is running or starting and it has a home
    assign st_ready = !draining && !flush_trig && (hit_any || any_free);
    assign accept   = st_valid && st_ready;

    // a drain starts on a flush event or a miss with every buffer open
    assign start_drain = !draining && (open_cnt != '0)
                         && (flush_trig || (st_valid && !hit_any && !any_free));

    assign out_valid = draining;
    assign pop       = out_valid && out_ready;

    // drain state: held until the last open buffer is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)                                  draining <= 1'b0;
        else if (start_drain)                        draining <= 1'b1;
        else if (pop && open_cnt == CNT_W'(1))       draining <= 1'b0;
    end

    wcb_free_pick #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_pick (
        .busy(slot_busy), .free_idx(free_idx), .any_free(any_free)
    );

    wcb_order_fifo #(.DEPTH(NUM_BUF), .IDX_W(IDX_W)) u_order (
        .clk(clk), .rst_n(rst_n),
        .push(accept && !hit_any), .push_idx(free_idx),
        .pop(pop), .head_idx(head_idx), .count(open_cnt)
    );

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
        // per-buffer steering of allocation, merge and release
        assign alloc_vec[i] = accept && !hit_any && (free_idx == IDX_W'(i));
        assign merge_vec[i] = accept && hit_vec[i];
        assign rel_vec[i]   = pop && (head_idx == IDX_W'(i));

        wcb_line_slot #(
            .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES),
            .WORD_BYTES(WORD_BYTES), .WIDX_W(WIDX_W)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .alloc(alloc_vec[i]), .merge(merge_vec[i]), .release_i(rel_vec[i]),
            .tag_in(st_tag), .word_sel(st_word), .wdata(st_data), .wbe(st_be),
            .busy(slot_busy[i]), .hit(hit_vec[i]),
            .tag(slot_tag[i]), .data(slot_data[i]), .mask(slot_mask[i])
        );
    end

    // present the oldest open buffer downstream
    assign out_addr = {slot_tag[head_idx], OFF_W'(0)};
    assign out_data = slot_data[head_idx];
    assign out_mask = slot_mask[head_idx];

    // R11
    unique_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_mask) && $stable(out_data)));
    // R2
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_busy) == int'(open_cnt));
    // R4
    merge_keeps_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit_any) |=> ($stable(open_cnt) && $stable(head_idx)));
endmodule

// File: tb/wc_line_combiner_bench.sv
`timescale 1ns/1ps
module wc_line_combiner_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0, flush_req = 1'b0, uc_req = 1'b0, out_ready = 1'b1;
    logic [31:0] st_addr = '0;
    logic [63:0] st_data = '0;
    logic [7:0]  st_be = '0;
    logic st_ready, out_valid;
    logic [31:0]  out_addr;
    logic [511:0] out_data;
    logic [63:0]  out_mask;

    int checks = 0, errors = 0, rec_n = 0, overlap = 0, acc_at = 0;
    bit done = 0;
    logic [31:0]  rec_addr [16];
    logic [511:0] rec_data [16];
    logic [63:0]  rec_mask [16];

    always #2.5 clk = ~clk;

    wc_line_combiner u_wc_line_combiner (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .flush_req(flush_req), .uc_req(uc_req), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_data(out_data),
        .out_mask(out_mask)
    );

    // capture handshakes just before the edge that completes them
    always @(negedge clk) begin
        #2;
        if (out_valid && st_ready) overlap++;
        if (out_valid && out_ready && rec_n < 16) begin
            rec_addr[rec_n] = out_addr;
            rec_data[rec_n] = out_data;
            rec_mask[rec_n] = out_mask;
            rec_n++;
        end
    end

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // model of one line: merge a word store into expected data and mask
    task automatic put(inout logic [511:0] d, inout logic [63:0] m,
                       input logic [31:0] a, input logic [63:0] v, input logic [7:0] be);
        for (int b = 0; b < 8; b++) begin
            if (be[b]) begin
                d[(a[5:3]*8 + b)*8 +: 8] = v[b*8 +: 8];
                m[a[5:3]*8 + b] = 1'b1;
            end
        end
    endtask

    task automatic store(input logic [31:0] a, input logic [63:0] v, input logic [7:0] be);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = v; st_be = be;
        forever begin
            #2;
            if (st_ready) break;
            @(negedge clk);
        end
        acc_at = rec_n;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic pulse(input bit uc);
        @(negedge clk);
        if (uc) uc_req = 1'b1; else flush_req = 1'b1;
        @(negedge clk);
        uc_req = 1'b0; flush_req = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic expect_txn(input string req, input int k, input logic [31:0] a,
                              input logic [63:0] m, input logic [511:0] d);
        chk({req, " addr"}, 512'(rec_addr[k]), 512'(a));
        chk({req, " mask"}, 512'(rec_mask[k]), 512'(m));
        chk({req, " data"}, rec_data[k], d);
    endtask

    task automatic t_reset();
        chk("R1 out_valid", 512'(out_valid), 512'(0));
        chk("R1 st_ready", 512'(st_ready), 512'(1));
    endtask

    task automatic t_basic();
        logic [511:0] d = '0; logic [63:0] m = '0;
        rec_n = 0;
        store(32'h1010, 64'h0123_4567_89AB_CDEF, 8'hFF);
        put(d, m, 32'h1010, 64'h0123_4567_89AB_CDEF, 8'hFF);
        pulse(0);
        chk("R5 count", 512'(rec_n), 512'(1));
        expect_txn("R2", 0, 32'h1000, m, d);
        chk("R2 mask value", 512'(m), 512'(64'h0000_0000_00FF_0000));
    endtask

    task automatic t_merge();
        logic [511:0] d = '0; logic [63:0] m = '0;
        rec_n = 0;
        store(32'h2008, 64'h1111_2222_3333_4444, 8'h0F);
        store(32'h2008, 64'h5555_6666_7777_8888, 8'hF0);
        store(32'h2030, 64'h0000_0000_0000_00AB, 8'h01);
        put(d, m, 32'h2008, 64'h1111_2222_3333_4444, 8'h0F);
        put(d, m, 32'h2008, 64'h5555_6666_7777_8888, 8'hF0);
        put(d, m, 32'h2030, 64'h0000_0000_0000_00AB, 8'h01);
        pulse(0);
        chk("R11 one txn", 512'(rec_n), 512'(1));
        expect_txn("R3", 0, 32'h2000, m, d);
        chk("R3 word1", 512'(rec_data[0][127:64]), 512'(64'h5555_6666_3333_4444));
    endtask

    task automatic t_order_uc();
        rec_n = 0;
        store(32'h3040, 64'hA1, 8'h01);
        store(32'h3000, 64'hB2, 8'h01);
        store(32'h3080, 64'hC3, 8'h01);
        store(32'h3048, 64'hD4, 8'h01);
        pulse(1);
        chk("R6 count", 512'(rec_n), 512'(3));
        chk("R4 first", 512'(rec_addr[0]), 512'(32'h3040));
        chk("R4 second", 512'(rec_addr[1]), 512'(32'h3000));
        chk("R6 third", 512'(rec_addr[2]), 512'(32'h3080));
        chk("R4 merged mask", 512'(rec_mask[0]), 512'(64'h0101));
    endtask

    task automatic t_full();
        rec_n = 0; overlap = 0;
        store(32'h40C0, 64'h1, 8'h01);
        store(32'h4000, 64'h2, 8'h01);
        store(32'h4080, 64'h3, 8'h01);
        store(32'h4040, 64'h4, 8'h01);
        chk("R7 no early txn", 512'(rec_n), 512'(0));
        store(32'h4100, 64'h5, 8'h01);
        chk("R7 drained before accept", 512'(acc_at), 512'(4));
        chk("R7 o0", 512'(rec_addr[0]), 512'(32'h40C0));
        chk("R7 o1", 512'(rec_addr[1]), 512'(32'h4000));
        chk("R7 o2", 512'(rec_addr[2]), 512'(32'h4080));
        chk("R7 o3", 512'(rec_addr[3]), 512'(32'h4040));
        pulse(0);
        chk("R7 new line", 512'(rec_addr[4]), 512'(32'h4100));
        chk("R7 total", 512'(rec_n), 512'(5));
        chk("R8 no store while draining", 512'(overlap), 512'(0));
    endtask

    task automatic t_backpressure();
        logic [31:0] held;
        rec_n = 0;
        store(32'h5040, 64'h77, 8'h01);
        store(32'h5000, 64'h88, 8'h01);
        @(negedge clk); out_ready = 1'b0; flush_req = 1'b1;
        @(negedge clk); flush_req = 1'b0;
        #2; held = out_addr;
        repeat (5) @(negedge clk);
        #2;
        chk("R9 valid held", 512'(out_valid), 512'(1));
        chk("R9 addr held", 512'(out_addr), 512'(held));
        chk("R9 first line", 512'(out_addr), 512'(32'h5040));
        chk("R8 stalled", 512'(st_ready), 512'(0));
        chk("R9 nothing taken", 512'(rec_n), 512'(0));
        @(negedge clk); out_ready = 1'b1;
        repeat (8) @(negedge clk);
        chk("R9 count", 512'(rec_n), 512'(2));
        chk("R9 second", 512'(rec_addr[1]), 512'(32'h5000));
    endtask

    task automatic t_empty_flush();
        rec_n = 0;
        pulse(0);
        pulse(1);
        chk("R10 no txn", 512'(rec_n), 512'(0));
        #2;
        chk("R10 ready", 512'(st_ready), 512'(1));
        chk("R10 idle", 512'(out_valid), 512'(0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_basic();
        t_merge();
        t_order_uc();
        t_full();
        t_backpressure();
        t_empty_flush();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end
endmodule